// File: doc/BRIEF.md
# Queued-Primitive I2C Bus Master

This block is an I2C bus master that software drives one bus primitive at a time. Each primitive is written as a byte into a command queue over a simple strobe-based register port. The primitives are start condition, stop condition, single bit 0, single bit 1, byte write, byte read and acknowledge check. An engine takes them from the queue strictly in arrival order and carries them out on open-drain SCL and SDA lines. Bytes it clocks in from the bus are stored in a small receive queue, which software drains through the same port.

Bus timing comes from the system clock. A 5-bit low divisor field and a prescale register for the upper bits form one divisor, and each bit cell is cut into four equal phases. A failed acknowledge check is a bus error. On a bus error the engine drops every queued command and stops until software reads the status register. Reading status also clears the interrupt line.

Top module: `i2c_cmd_engine`

## Requirements
- R1: After reset both lines are released (`sclOe`=0, `sdaOe`=0), `irq` is low, the status register reads 0x20 (only the command-queue-empty bit 5 set) and the prescale register (address 1) reads 1.
- R2: Address 0 holds the enable in bit 7 and the low divisor in bits 4:0. Address 1 holds the prescale, and a write whose value is zero is ignored. While the enable is clear, no command is taken from the queue and neither line changes.
- R3: The SCL period is 4 × (32 × prescale + low divisor + 2) system clocks.
- R4: Commands run in the order written. The opcodes are 0x01 start, 0x02 stop, 0x04 single bit 0, 0x05 single bit 1, 0x08 byte write, 0x10 acknowledge check and 0x13 byte read. Any other value is removed from the queue with no bus activity.
- R5: A start pulls SDA low while SCL is high and then pulls SCL low. A stop releases SDA while SCL is high. Status bit 6 (bus busy) is set after a start and cleared after a stop.
- R6: The byte write takes the next queue entry as raw data and sends it MSB first. This holds when the value is 0x13, and when that entry is written only after the queue has gone empty, in which case the engine holds the lines and waits.
- R7: The byte read clocks in eight bits MSB first and pushes them to the receive queue. It gives no ninth clock; the master's acknowledge is a separate single-bit command (0 acknowledges, 1 refuses).
- R8: If SDA is high when the acknowledge check samples it, status bit 4 (bus error) is set and the command queue is flushed. Nothing more runs until status is read.
- R9: The command queue holds 32 entries. Status bit 0 shows it is full. A write while full is dropped and sets status bit 1 (overflow).
- R10: Reading address 2 pops one received byte. Status bit 3 is set while bytes are waiting. A read of address 2 with the queue empty returns 0 and sets status bit 2 (underflow).
- R11: `irq` rises on a bus error, an overflow, an underflow or a received byte. A read of status (address 3) clears `irq` and the sticky bits 1, 2 and 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effects on addresses 2 and 3) |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, valid in the cycle of the strobe |
| sdaIn | input | 1 | Sampled SDA line level |
| sclOe | output | 1 | Pull SCL low when 1, release when 0 |
| sdaOe | output | 1 | Pull SDA low when 1, release when 0 |
| irq | output | 1 | Block interrupt |

## Verification
The assertions check rules that hold in every cycle. The two lines never move in the same cycle, and they stay frozen while the enable has been clear. A write to a full queue raises the overflow flag. A new bus error arrives with an empty command queue. `irq` only falls on a status read. The queue is never full and empty at once. Only the bench's bus scenarios can show the rest. These cover the bit order on the wire, late or 0x13-valued write data, the master's ACK/NACK after reads, the SCL period, the stop being lost after a flush, and the sticky flags read back.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  localparam logic [7:0] OP_START = 8'h01;
  localparam logic [7:0] OP_STOP  = 8'h02;
  localparam logic [7:0] OP_WBIT0 = 8'h04;
  localparam logic [7:0] OP_WBIT1 = 8'h05;
  localparam logic [7:0] OP_WBYTE = 8'h08;
  localparam logic [7:0] OP_VACK  = 8'h10;
  localparam logic [7:0] OP_RBYTE = 8'h13;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_PRE  = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  typedef struct packed {
    logic popCmd;
    logic loadData;
    logic shiftBit;
    logic pushRd;
    logic setErr;
  } engStrobe_t;

  typedef enum logic [1:0] {ENG_IDLE, ENG_DATA, ENG_RUN} engState_t;

  function automatic logic opKnown(input logic [7:0] op);
    return (op == OP_START) || (op == OP_STOP) || (op == OP_WBIT0) ||
           (op == OP_WBIT1) || (op == OP_WBYTE) || (op == OP_VACK) ||
           (op == OP_RBYTE);
  endfunction
endpackage

// File: rtl/i2c_fifo.sv
module i2c_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0] FULLCNT = (AW + 1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0] count;
  logic doPush, doPop;

  always_comb begin
    doPush = push && !full && !flush;
    doPop  = pop && !empty && !flush;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      count <= count + {{AW{1'b0}}, doPush} - {{AW{1'b0}}, doPop};
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  assign dout  = mem[rdPtr];
  assign empty = (count == '0);
  assign full  = (count == FULLCNT);
endmodule

// File: rtl/i2c_eng_dp.sv
module i2c_eng_dp
  import i2c_cmd_pkg::*;
#(
  parameter int CMD_DEPTH = 32,
  parameter int RD_DEPTH  = 4,
  parameter int PRE_W     = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       sdaIn,
  input  engStrobe_t strb,
  input  logic       busBusy,
  output logic [7:0] cmdHead,
  output logic       cmdEmpty,
  output logic       cmdFull,
  output logic       cmdOvf,
  output logic       txBit,
  output logic       enable,
  output logic       tick,
  output logic       busErr,
  output logic       irq
);
  localparam int DIV_W = 5 + PRE_W;

  logic [4:0] divLow;
  logic [PRE_W-1:0] preR;
  logic [DIV_W:0] divCnt, divLimit;
  logic [7:0] shiftR, rdHead;
  logic rdEmpty, rdFull, uflR;
  logic wrCmd, rdData, rdStat, ovfEv, uflEv;
  logic [7:0] status;

  assign wrCmd  = regWrEn && (regAddr == ADDR_DATA);
  assign rdData = regRdEn && (regAddr == ADDR_DATA);
  assign rdStat = regRdEn && (regAddr == ADDR_STAT);
  assign ovfEv  = wrCmd && cmdFull;
  assign uflEv  = rdData && rdEmpty;

  i2c_fifo #(.WIDTH(8), .DEPTH(CMD_DEPTH)) u_cmdq (
    .clk(clk), .rstN(rstN), .push(wrCmd), .pop(strb.popCmd), .flush(strb.setErr),
    .din(regWrData), .dout(cmdHead), .empty(cmdEmpty), .full(cmdFull));

  i2c_fifo #(.WIDTH(8), .DEPTH(RD_DEPTH)) u_rdq (
    .clk(clk), .rstN(rstN), .push(strb.pushRd), .pop(rdData), .flush(1'b0),
    .din(shiftR), .dout(rdHead), .empty(rdEmpty), .full(rdFull));

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable <= 1'b0;
      divLow <= '0;
      preR   <= PRE_W'(1);
    end else if (regWrEn) begin
      if (regAddr == ADDR_CTRL) begin
        enable <= regWrData[7];
        divLow <= regWrData[4:0];
      end else if (regAddr == ADDR_PRE && regWrData[PRE_W-1:0] != '0) begin
        preR <= regWrData[PRE_W-1:0];
      end
    end
  end

  // quarter-phase tick generator
  assign divLimit = {1'b0, preR, divLow} + 1'b1;
  assign tick = enable && (divCnt == divLimit);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (!enable || tick) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  // bit shifter shared by byte write and byte read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftR <= '0;
    else if (strb.loadData) shiftR <= cmdHead;
    else if (strb.shiftBit) shiftR <= {shiftR[6:0], sdaIn};
  end
  assign txBit = shiftR[7];

  // sticky flags and interrupt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdOvf <= 1'b0;
      uflR   <= 1'b0;
      busErr <= 1'b0;
      irq    <= 1'b0;
    end else begin
      cmdOvf <= ovfEv ? 1'b1 : (rdStat ? 1'b0 : cmdOvf);
      uflR   <= uflEv ? 1'b1 : (rdStat ? 1'b0 : uflR);
      busErr <= strb.setErr ? 1'b1 : (rdStat ? 1'b0 : busErr);
      if (strb.setErr || ovfEv || uflEv || strb.pushRd) irq <= 1'b1;
      else if (rdStat) irq <= 1'b0;
    end
  end

  assign status = {1'b0, busBusy, cmdEmpty, busErr, !rdEmpty, uflR, cmdOvf, cmdFull};

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdData = {enable, 2'b00, divLow};
      ADDR_PRE:  regRdData = 8'(preR);
      ADDR_DATA: regRdData = rdEmpty ? 8'h00 : rdHead;
      default:   regRdData = status;
    endcase
  end

  logic unusedRd;
  assign unusedRd = rdFull;
endmodule

// File: rtl/i2c_eng_ctrl.sv
module i2c_eng_ctrl
  import i2c_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       enable,
  input  logic       busErr,
  input  logic       cmdEmpty,
  input  logic [7:0] cmdHead,
  input  logic       txBit,
  input  logic       sdaIn,
  output engStrobe_t strb,
  output logic       sclOe,
  output logic       sdaOe,
  output logic       busBusy
);
  engState_t state;
  logic [7:0] opcode;
  logic [1:0] phase;
  logic [2:0] bitCnt;
  logic bitVal, isBitOp;

  assign isBitOp = (opcode != OP_START) && (opcode != OP_STOP);

  always_comb begin
    case (opcode)
      OP_WBIT0: bitVal = 1'b0;
      OP_WBIT1: bitVal = 1'b1;
      OP_WBYTE: bitVal = txBit;
      default:  bitVal = 1'b1;
    endcase
  end

  always_comb begin
    strb = '0;
    case (state)
      ENG_IDLE: strb.popCmd = enable && !busErr && !cmdEmpty;
      ENG_DATA: begin
        strb.popCmd   = enable && !cmdEmpty;
        strb.loadData = enable && !cmdEmpty;
      end
      ENG_RUN: if (tick) begin
        strb.shiftBit = (phase == 2'd2) && isBitOp;
        strb.setErr   = (phase == 2'd2) && (opcode == OP_VACK) && sdaIn;
        strb.pushRd   = (phase == 2'd3) && (bitCnt == 3'd0) && (opcode == OP_RBYTE);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ENG_IDLE;
      opcode  <= '0;
      phase   <= '0;
      bitCnt  <= '0;
      sclOe   <= 1'b0;
      sdaOe   <= 1'b0;
      busBusy <= 1'b0;
    end else begin
      case (state)
        ENG_IDLE: if (strb.popCmd) begin
          opcode <= cmdHead;
          phase  <= '0;
          bitCnt <= (cmdHead == OP_RBYTE) ? 3'd7 : 3'd0;
          if (cmdHead == OP_WBYTE) state <= ENG_DATA;
          else if (opKnown(cmdHead)) state <= ENG_RUN;
        end
        ENG_DATA: if (strb.popCmd) begin
          bitCnt <= 3'd7;
          state  <= ENG_RUN;
        end
        ENG_RUN: if (tick) begin
          phase <= phase + 1'b1;
          if (phase == 2'd3) begin
            if (bitCnt == 3'd0) state <= ENG_IDLE;
            else bitCnt <= bitCnt - 1'b1;
          end
          if (opcode == OP_START) begin
            case (phase)
              2'd0: sdaOe <= 1'b0;
              2'd1: sclOe <= 1'b0;
              2'd2: sdaOe <= 1'b1;
              default: begin sclOe <= 1'b1; busBusy <= 1'b1; end
            endcase
          end else if (opcode == OP_STOP) begin
            case (phase)
              2'd0: sdaOe <= 1'b1;
              2'd1: sclOe <= 1'b0;
              2'd2: sdaOe <= 1'b0;
              default: busBusy <= 1'b0;
            endcase
          end else begin
            case (phase)
              2'd0: sdaOe <= ~bitVal;
              2'd1: sclOe <= 1'b0;
              2'd2: ;
              default: sclOe <= 1'b1;
            endcase
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
  import i2c_cmd_pkg::*;
#(
  parameter int CMD_DEPTH = 32,
  parameter int RD_DEPTH  = 4,
  parameter int PRE_W     = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       sdaIn,
  output logic       sclOe,
  output logic       sdaOe,
  output logic       irq
);
  engStrobe_t strb;
  logic [7:0] cmdHead;
  logic cmdEmpty, cmdFull, cmdOvf, txBit, enable, tick, busErr, busBusy;

  i2c_eng_dp #(.CMD_DEPTH(CMD_DEPTH), .RD_DEPTH(RD_DEPTH), .PRE_W(PRE_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sdaIn(sdaIn), .strb(strb),
    .busBusy(busBusy), .cmdHead(cmdHead), .cmdEmpty(cmdEmpty), .cmdFull(cmdFull),
    .cmdOvf(cmdOvf), .txBit(txBit), .enable(enable), .tick(tick), .busErr(busErr),
    .irq(irq));

  i2c_eng_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .enable(enable), .busErr(busErr),
    .cmdEmpty(cmdEmpty), .cmdHead(cmdHead), .txBit(txBit), .sdaIn(sdaIn),
    .strb(strb), .sclOe(sclOe), .sdaOe(sdaOe), .busBusy(busBusy));
endmodule

// File: rtl/i2c_cmd_engine_chk.sv
module i2c_cmd_engine_chk (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic       regRdEn,
  input logic [1:0] regAddr,
  input logic       sclOe,
  input logic       sdaOe,
  input logic       irq,
  input logic       enable,
  input logic       busErr,
  input logic       cmdEmpty,
  input logic       cmdFull,
  input logic       cmdOvf
);
  // R2
  disabled_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && $past(!enable)) |-> ($stable(sclOe) && $stable(sdaOe)));
  // R5
  one_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!$stable(sclOe) && !$stable(sdaOe)));
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd2 && cmdFull) |=> cmdOvf);
  // R9
  full_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdFull && cmdEmpty));
  // R8
  err_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busErr) |-> cmdEmpty);
  // R11
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(regRdEn && regAddr == 2'd3));
endmodule

bind i2c_cmd_engine i2c_cmd_engine_chk u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
  .sclOe(sclOe), .sdaOe(sdaOe), .irq(irq), .enable(enable), .busErr(busErr),
  .cmdEmpty(cmdEmpty), .cmdFull(cmdFull), .cmdOvf(cmdOvf));

// File: tb/test_i2c_cmd_engine.sv
`timescale 1ns/1ps
module test_i2c_cmd_engine;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic sclOe, sdaOe, irq;
  logic slvLow;
  wire sclBus = !sclOe;
  wire sdaBus = !(sdaOe || slvLow);

  int total = 0, failed = 0;
  int cyc = 0;
  int startCnt = 0, stopCnt = 0, monCnt = 0, slvIdx = -1;
  logic [0:127] monBits;
  int riseT [0:127];
  logic [63:0] slvPlan = '0;
  int curP = 34;

  i2c_cmd_engine i_i2c_cmd_engine (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sdaIn(sdaBus),
    .sclOe(sclOe), .sdaOe(sdaOe), .irq(irq));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // bus monitor and slave responder
  always @(negedge sdaBus) if (sclBus) begin startCnt++; monCnt = 0; slvIdx = -1; end
  always @(posedge sdaBus) if (sclBus) stopCnt++;
  always @(posedge sclBus) begin
    if (monCnt < 128) begin monBits[monCnt] = sdaBus; riseT[monCnt] = cyc; end
    monCnt++;
  end
  always @(negedge sclBus) slvIdx++;
  always_comb slvLow = (slvIdx >= 0 && slvIdx < 64) ? slvPlan[slvIdx] : 1'b0;

  function automatic logic [7:0] stat(input logic busy, empty, err, rdy, ufl, ovf, full);
    return {1'b0, busy, empty, err, rdy, ufl, ovf, full};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic waitBits(input int nbits);
    repeat (nbits * 4 * curP + curP + 20) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] monByte(input int base);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[7 - i] = monBits[base + i];
    return b;
  endfunction

  // write one byte with acknowledge check and stop; returns after the bus settles
  task automatic writeTxn(input logic [7:0] d, input logic ack);
    logic [7:0] s;
    int stops0;
    slvPlan = '0;
    slvPlan[8] = ack;
    stops0 = stopCnt;
    wrReg(2'd2, 8'h01); wrReg(2'd2, 8'h08); wrReg(2'd2, d);
    wrReg(2'd2, 8'h10); wrReg(2'd2, 8'h02);
    waitBits(11);
    check("R6 write byte on wire", monByte(0), d);
    if (ack) begin
      check("R5 stop seen", stopCnt - stops0, 1);
      check("R5 frame length", monCnt, 10);
      rdReg(2'd3, s);
      check("R5 R8 status after acked write", s, stat(0, 1, 0, 0, 0, 0, 0));
    end else begin
      check("R8 no stop after flush", stopCnt - stops0, 0);
      check("R8 irq on bus error", irq, 1);
      rdReg(2'd3, s);
      check("R8 status on NACK", s, stat(1, 1, 1, 0, 0, 0, 0));
      rdReg(2'd3, s);
      check("R11 status read clears error", s, stat(1, 1, 0, 0, 0, 0, 0));
      check("R11 irq cleared", irq, 0);
      wrReg(2'd2, 8'h02);
      waitBits(1);
      rdReg(2'd3, s);
      check("R5 busy cleared by stop", s, stat(0, 1, 0, 0, 0, 0, 0));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    logic [7:0] s, d, b1, b2;
    int starts0;
    void'($urandom(32'd1357));
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    check("R1 sclOe", sclOe, 0);
    check("R1 sdaOe", sdaOe, 0);
    check("R1 irq", irq, 0);
    rdReg(2'd3, s); check("R1 status", s, 8'h20);
    rdReg(2'd1, s); check("R1 prescale", s, 1);

    // R2 zero prescale ignored
    wrReg(2'd1, 8'h00);
    rdReg(2'd1, s); check("R2 zero prescale ignored", s, 1);

    // R3 period with low divisor 3: P = 32+3+2
    wrReg(2'd0, 8'h83); curP = 37;
    rdReg(2'd0, s); check("R2 control readback", s, 8'h83);
    writeTxn(8'hA5, 1'b1);
    check("R3 SCL period", riseT[1] - riseT[0], 4 * 37);
    check("R3 SCL period late bit", riseT[8] - riseT[7], 4 * 37);

    // R6 data 0x13 arriving after the queue emptied
    slvPlan = '0; slvPlan[8] = 1'b1;
    wrReg(2'd2, 8'h01); wrReg(2'd2, 8'h08);
    waitBits(1);
    rdReg(2'd3, s); check("R6 waiting with empty queue", s, stat(1, 1, 0, 0, 0, 0, 0));
    check("R6 SCL held low while waiting", sclOe, 1);
    check("R6 no clocks while waiting", monCnt, 0);
    wrReg(2'd2, 8'h13); wrReg(2'd2, 8'h10); wrReg(2'd2, 8'h02);
    waitBits(10);
    check("R6 late 0x13 sent as data", monByte(0), 8'h13);
    rdReg(2'd3, s); check("R6 0x13 not run as read", s, stat(0, 1, 0, 0, 0, 0, 0));

    // R7 read transaction, address byte equal to the read opcode
    b1 = 8'($urandom); b2 = 8'($urandom);
    slvPlan = '0; slvPlan[8] = 1'b1;
    for (int i = 0; i < 8; i++) begin
      slvPlan[9 + i]  = ~b1[7 - i];
      slvPlan[18 + i] = ~b2[7 - i];
    end
    wrReg(2'd2, 8'h01); wrReg(2'd2, 8'h08); wrReg(2'd2, 8'h13); wrReg(2'd2, 8'h10);
    wrReg(2'd2, 8'h13); wrReg(2'd2, 8'h04); wrReg(2'd2, 8'h13); wrReg(2'd2, 8'h05);
    wrReg(2'd2, 8'h02);
    waitBits(29);
    check("R7 frame length", monCnt, 28);
    check("R6 0x13 address sent", monByte(0), 8'h13);
    check("R7 master ACK bit", monBits[17], 0);
    check("R7 master NACK bit", monBits[26], 1);
    check("R11 irq on received byte", irq, 1);
    rdReg(2'd3, s); check("R10 data ready", s, stat(0, 1, 0, 1, 0, 0, 0));
    rdReg(2'd2, s); check("R7 first byte", s, b1);
    rdReg(2'd2, s); check("R7 second byte", s, b2);

    // R10 underflow
    rdReg(2'd2, s); check("R10 empty read returns 0", s, 0);
    check("R11 irq on underflow", irq, 1);
    rdReg(2'd3, s); check("R10 underflow flag", s, stat(0, 1, 0, 0, 1, 0, 0));
    rdReg(2'd3, s); check("R11 underflow cleared", s, stat(0, 1, 0, 0, 0, 0, 0));

    // R8 directed NACK with queued work flushed
    slvPlan = '0;
    starts0 = startCnt;
    wrReg(2'd2, 8'h01); wrReg(2'd2, 8'h08); wrReg(2'd2, 8'h5C); wrReg(2'd2, 8'h10);
    wrReg(2'd2, 8'h08); wrReg(2'd2, 8'hFF); wrReg(2'd2, 8'h02);
    waitBits(12);
    check("R8 frame stopped after NACK", monCnt, 9);
    rdReg(2'd3, s); check("R8 error and flush", s, stat(1, 1, 1, 0, 0, 0, 0));
    wrReg(2'd2, 8'h02);
    waitBits(1);
    check("R8 one start only", startCnt - starts0, 1);

    // random write transactions with random divisor and acknowledge
    for (int it = 0; it < 4; it++) begin
      int low;
      low = $urandom % 32;
      curP = 32 + low + 2;
      wrReg(2'd0, 8'h80 | 8'(low));
      d = 8'($urandom);
      writeTxn(d, ($urandom % 4) != 0);
      check("R3 random period", riseT[2] - riseT[1], 4 * curP);
    end

    // R9 overflow with engine disabled, R2 freeze, R4 unknown opcodes
    wrReg(2'd0, 8'h00);
    for (int i = 0; i < 32; i++) wrReg(2'd2, 8'h00);
    rdReg(2'd3, s); check("R9 full", s, stat(0, 0, 0, 0, 0, 0, 1));
    check("R2 no command taken while disabled", sclOe | sdaOe, 0);
    wrReg(2'd2, 8'h00);
    check("R11 irq on overflow", irq, 1);
    rdReg(2'd3, s); check("R9 overflow flag", s, stat(0, 0, 0, 0, 0, 1, 1));
    rdReg(2'd3, s); check("R11 overflow cleared", s, stat(0, 0, 0, 0, 0, 0, 1));
    starts0 = startCnt;
    wrReg(2'd0, 8'h80); curP = 34;
    repeat (200) @(posedge clk);
    @(negedge clk);
    rdReg(2'd3, s); check("R4 unknown opcodes drained", s, stat(0, 1, 0, 0, 0, 0, 0));
    check("R4 no bus activity", startCnt - starts0, 0);
    check("R4 lines released", sclOe | sdaOe, 0);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule